// File: doc/BRIEF.md
# Three-Wire Latched Control Receiver

This block takes configuration words from a host controller over three slow lines: a serial clock, a data line and a latch line. All three are oversampled by a fast system clock. Bits are shifted in on each serial clock rise. A latch rise then closes the frame. If the frame holds exactly 24 bits, its last two bits name one of four setting slots, and the remaining 22 bits become the new contents of that slot.

Before a frame is applied it is screened. A frame of the wrong length, or one that carries a code outside the defined set, leaves every setting untouched and raises a one-cycle flag. An accepted frame raises a one-cycle update strobe that carries the slot index, so downstream analog control can retime its changes.

The settings are held as decoded fields:
- a source selector,
- three 2-bit 6 dB step codes,
- a global mute,
- four record-path enables,
- six 7-bit channel attenuation codes, each with its own mute flag,
- a tone attenuation code,
- a tone enable,
- a single bit that picks either the loudness tap or the balanced converter output.

Top module: `ctl3w_rx`

## Requirements
- R1: A frame is 24 bits, sampled on serial clock rises, with D0 received first; inside every field the bit received earlier is the more significant one.
- R2: Settings change only after a latch rise; bits shifted in without a latch leave every output unchanged.
- R3: D22 (more significant) and D23 form the slot index, and only the fields of the addressed slot change. Layout: slot 0 has D0–D3 selector, D4–D5 input attenuation, D6–D7 input gain, D8–D9 output gain, D10 global mute, D11–D14 record enables (D11 lands on bit 3), D15–D21 reserved. Slot 1 has channel 0 in D0–D6, channel 1 in D7–D13, channel 2 in D14–D20, and D21 reserved. Slot 2 has the same layout for channels 3–5. Slot 3 has D0–D1 tone attenuation, D2 loudness select, D3 tone enable, D4–D21 reserved.
- R4: A channel code N in 0..99 means N dB of attenuation and appears on vol_code_o[7j+6:7j]; code 120 means full mute and sets vol_mute_o[j].
- R5: The 4-bit selector value 0 means all sources off, and values 1..10 pick source 1..10.
- R6: Input attenuation, input gain, output gain and tone attenuation are 2-bit codes meaning 0..3 steps of 6 dB, and they are presented unchanged.
- R7: Reset sets these defaults: selector 0, all 2-bit codes 0, global mute 1, record enables 0, every channel code 120, loudness select 0, tone disabled. Reset also discards any partial frame.
- R8: A latch rise after any number of serial clock rises other than 24 discards the frame, leaves all settings unchanged and pulses len_err_o for one cycle.
- R9: A 24-bit frame is rejected as a whole when it carries any of the following, and rej_o then pulses for one cycle with nothing changed:
  - a selector above 10;
  - a channel code in 100..127 other than 120;
  - a nonzero reserved bit.
- R10: Each accepted frame pulses upd_o for exactly one cycle, with upd_slot_o equal to the slot written.
- R11: loud_en_o equals the loudness select bit and bal_en_o is its complement, so the two are never both set.
- R12: A latch rise seen in the same system cycle as the 24th serial clock rise counts that bit, and the frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the serial clock rate |
| rst_n | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial clock line |
| ser_dat_i | input | 1 | Serial data line |
| ser_lat_i | input | 1 | Latch line |
| src_sel_o | output | 4 | Source selector |
| in_att_o | output | 2 | Input attenuation code |
| in_gain_o | output | 2 | Input gain code |
| out_gain_o | output | 2 | Output gain code |
| mute_all_o | output | 1 | Global mute |
| rec_en_o | output | 4 | Record path enables |
| vol_code_o | output | 42 | Six 7-bit channel attenuation codes, channel j at bits 7j+6:7j |
| vol_mute_o | output | 6 | Per-channel full-mute flags |
| tone_att_o | output | 2 | Tone attenuation code |
| tone_en_o | output | 1 | Tone path enable |
| loud_en_o | output | 1 | Loudness tap enabled |
| bal_en_o | output | 1 | Balanced converter output enabled |
| upd_o | output | 1 | One-cycle update strobe |
| upd_slot_o | output | 2 | Index of the slot just written |
| len_err_o | output | 1 | One-cycle frame length error pulse |
| rej_o | output | 1 | One-cycle prohibited-code reject pulse |

## Verification
The final serial clock rise and the latch rise can land in the same system cycle. In that case shifting and committing must merge, so that the bit arriving in that cycle both completes the count and becomes part of the stored word. The bench provokes this by raising the serial clock and latch lines together on the last bit, so both edges pass through matched synchronizers. It then judges the result at the ports: exactly one update strobe for the right slot, no length error, and outputs that carry the last bit's value.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    localparam int FRAME_W      = 24;
    localparam int ADDR_W       = 2;
    localparam int PAY_W        = FRAME_W - ADDR_W;
    localparam int NSLOT        = 1 << ADDR_W;
    localparam int SEL_W        = 4;
    localparam int CODE_W       = 2;
    localparam int REC_W        = 4;
    localparam int VOL_W        = 7;
    localparam int VOL_PER_SLOT = 3;
    localparam int NVOL         = 2 * VOL_PER_SLOT;

    localparam logic [SEL_W-1:0] SEL_MAX  = 4'd10;
    localparam logic [VOL_W-1:0] VOL_MAX  = 7'd99;
    localparam logic [VOL_W-1:0] VOL_MUTE = 7'd120;

    // payload index = PAY_W-1-D ; fields listed by their most significant bit
    localparam int P_SEL    = PAY_W - 1;
    localparam int P_IATT   = P_SEL - SEL_W;
    localparam int P_IGAIN  = P_IATT - CODE_W;
    localparam int P_OGAIN  = P_IGAIN - CODE_W;
    localparam int P_MUTE   = P_OGAIN - CODE_W;
    localparam int P_REC    = P_MUTE - 1;
    localparam int RSV0_W   = P_REC - REC_W + 1;
    localparam int RSV12_W  = PAY_W - VOL_PER_SLOT * VOL_W;
    localparam int P_TATT   = PAY_W - 1;
    localparam int P_LOUD   = P_TATT - CODE_W;
    localparam int P_TONE   = P_LOUD - 1;
    localparam int RSV3_W   = P_TONE;

    typedef struct packed {
        logic [SEL_W-1:0]             sel;
        logic [CODE_W-1:0]            in_att;
        logic [CODE_W-1:0]            in_gain;
        logic [CODE_W-1:0]            out_gain;
        logic                         mute_all;
        logic [REC_W-1:0]             rec_en;
        logic [NVOL-1:0][VOL_W-1:0]   vol;
        logic [CODE_W-1:0]            tone_att;
        logic                         loud;
        logic                         tone_en;
    } cfg_t;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c = '0;
        c.mute_all = 1'b1;
        for (int j = 0; j < NVOL; j++) c.vol[j] = VOL_MUTE;
        return c;
    endfunction

    function automatic logic vol_ok(input logic [VOL_W-1:0] v);
        return (v <= VOL_MAX) || (v == VOL_MUTE);
    endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int STAGES = 2,
    parameter bit EDGE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic out_o
);
    localparam int DEPTH = STAGES + (EDGE ? 1 : 0);

    logic [DEPTH-1:0] sr_d, sr_q;

    always_comb sr_d = {sr_q[DEPTH-2:0], line_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    generate
        if (EDGE) begin : g_rise
            assign out_o = sr_q[STAGES-1] & ~sr_q[STAGES];
        end else begin : g_level
            assign out_o = sr_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ctl3w_frame.sv
module ctl3w_frame
    import ctl3w_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_rise_i,
    input  logic               dat_i,
    input  logic               lat_rise_i,
    output logic               frm_ok_o,
    output logic               len_err_o,
    output logic [FRAME_W-1:0] frm_word_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic               ok;
        logic               err;
    } frame_t;

    frame_t d, q;

    always_comb begin
        d     = q;
        d.ok  = 1'b0;
        d.err = 1'b0;
        if (clk_rise_i) begin
            d.sh = {q.sh[FRAME_W-2:0], dat_i};
            if (q.cnt != CNT_SAT) d.cnt = q.cnt + 1'b1;
        end
        // a latch in the same cycle as a clock rise sees the count including it
        if (lat_rise_i) begin
            if (d.cnt == CNT_FULL) d.ok  = 1'b1;
            else                   d.err = 1'b1;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frm_ok_o   = q.ok;
    assign len_err_o  = q.err;
    assign frm_word_o = q.sh;

    assert_len_err_on_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> $past(lat_rise_i)) else $error("length error without latch");

    assert_count_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ok || q.err) |-> (q.cnt == '0)) else $error("count not restarted after latch");
endmodule

// File: rtl/ctl3w_bank.sv
module ctl3w_bank
    import ctl3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_ok_i,
    input  logic [FRAME_W-1:0] frm_word_i,
    output cfg_t               cfg_o,
    output logic               upd_o,
    output logic [ADDR_W-1:0]  upd_slot_o,
    output logic               rej_o
);
    typedef struct packed {
        cfg_t              cfg;
        logic              upd;
        logic [ADDR_W-1:0] uslot;
        logic              rej;
    } bank_t;

    bank_t             d, q;
    logic [ADDR_W-1:0] addr;
    logic [PAY_W-1:0]  pay;
    cfg_t              nxt;
    logic              bad;
    int                base;

    always_comb begin
        addr = frm_word_i[ADDR_W-1:0];
        pay  = frm_word_i[FRAME_W-1:ADDR_W];
        nxt  = q.cfg;
        bad  = 1'b0;
        base = 0;
        case (addr)
            2'd0: begin
                nxt.sel      = pay[P_SEL   -: SEL_W];
                nxt.in_att   = pay[P_IATT  -: CODE_W];
                nxt.in_gain  = pay[P_IGAIN -: CODE_W];
                nxt.out_gain = pay[P_OGAIN -: CODE_W];
                nxt.mute_all = pay[P_MUTE];
                nxt.rec_en   = pay[P_REC   -: REC_W];
                bad = (pay[P_SEL -: SEL_W] > SEL_MAX) || (pay[RSV0_W-1:0] != '0);
            end
            2'd1, 2'd2: begin
                base = (addr == 2'd2) ? VOL_PER_SLOT : 0;
                for (int k = 0; k < VOL_PER_SLOT; k++) begin
                    nxt.vol[base+k] = pay[PAY_W-1-VOL_W*k -: VOL_W];
                    if (!vol_ok(pay[PAY_W-1-VOL_W*k -: VOL_W])) bad = 1'b1;
                end
                if (pay[RSV12_W-1:0] != '0) bad = 1'b1;
            end
            default: begin
                nxt.tone_att = pay[P_TATT -: CODE_W];
                nxt.loud     = pay[P_LOUD];
                nxt.tone_en  = pay[P_TONE];
                bad = (pay[RSV3_W-1:0] != '0);
            end
        endcase

        d     = q;
        d.upd = 1'b0;
        d.rej = 1'b0;
        if (frm_ok_i) begin
            if (bad) begin
                d.rej = 1'b1;
            end else begin
                d.cfg   = nxt;
                d.upd   = 1'b1;
                d.uslot = addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg   <= cfg_default();
            q.upd   <= 1'b0;
            q.uslot <= '0;
            q.rej   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cfg_o      = q.cfg;
    assign upd_o      = q.upd;
    assign upd_slot_o = q.uslot;
    assign rej_o      = q.rej;

    assert_sel_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.cfg.sel <= SEL_MAX) else $error("stored selector out of range");

    assert_upd_rej_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.upd && q.rej)) else $error("update and reject together");

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.cfg) |-> q.upd) else $error("settings changed without update");

    assert_upd_from_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.upd |-> $past(frm_ok_i)) else $error("update without a complete frame");

    generate
        for (genvar j = 0; j < NVOL; j++) begin : g_vchk
            assert_vol_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
                vol_ok(q.cfg.vol[j])) else $error("stored channel code prohibited");
        end
    endgenerate
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_clk_i,
    input  logic                    ser_dat_i,
    input  logic                    ser_lat_i,
    output logic [SEL_W-1:0]        src_sel_o,
    output logic [CODE_W-1:0]       in_att_o,
    output logic [CODE_W-1:0]       in_gain_o,
    output logic [CODE_W-1:0]       out_gain_o,
    output logic                    mute_all_o,
    output logic [REC_W-1:0]        rec_en_o,
    output logic [NVOL*VOL_W-1:0]   vol_code_o,
    output logic [NVOL-1:0]         vol_mute_o,
    output logic [CODE_W-1:0]       tone_att_o,
    output logic                    tone_en_o,
    output logic                    loud_en_o,
    output logic                    bal_en_o,
    output logic                    upd_o,
    output logic [ADDR_W-1:0]       upd_slot_o,
    output logic                    len_err_o,
    output logic                    rej_o
);
    logic               clk_rise, dat_lvl, lat_rise;
    logic               frm_ok;
    logic [FRAME_W-1:0] frm_word;
    cfg_t               cfg;

    ctl3w_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_sclk (
        .clk(clk), .rst_n(rst_n), .line_i(ser_clk_i), .out_o(clk_rise));
    ctl3w_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b0)) u_sdat (
        .clk(clk), .rst_n(rst_n), .line_i(ser_dat_i), .out_o(dat_lvl));
    ctl3w_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_slat (
        .clk(clk), .rst_n(rst_n), .line_i(ser_lat_i), .out_o(lat_rise));

    ctl3w_frame #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .clk_rise_i(clk_rise), .dat_i(dat_lvl),
        .lat_rise_i(lat_rise), .frm_ok_o(frm_ok), .len_err_o(len_err_o),
        .frm_word_o(frm_word));

    ctl3w_bank u_bank (
        .clk(clk), .rst_n(rst_n), .frm_ok_i(frm_ok), .frm_word_i(frm_word),
        .cfg_o(cfg), .upd_o(upd_o), .upd_slot_o(upd_slot_o), .rej_o(rej_o));

    assign src_sel_o  = cfg.sel;
    assign in_att_o   = cfg.in_att;
    assign in_gain_o  = cfg.in_gain;
    assign out_gain_o = cfg.out_gain;
    assign mute_all_o = cfg.mute_all;
    assign rec_en_o   = cfg.rec_en;
    assign vol_code_o = cfg.vol;
    assign tone_att_o = cfg.tone_att;
    assign tone_en_o  = cfg.tone_en;
    assign loud_en_o  = cfg.loud;
    assign bal_en_o   = ~cfg.loud;

    generate
        for (genvar j = 0; j < NVOL; j++) begin : g_vmute
            assign vol_mute_o[j] = (cfg.vol[j] == VOL_MUTE);
        end
    endgenerate

    assert_strobe_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o) else $error("update strobe wider than one cycle");
endmodule

// File: tb/tb_ctl3w_rx.sv
module tb_ctl3w_rx;
    import ctl3w_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;
    localparam int NV         = 13;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
    logic [3:0]  src_sel_o;
    logic [1:0]  in_att_o, in_gain_o, out_gain_o, tone_att_o, upd_slot_o;
    logic        mute_all_o, tone_en_o, loud_en_o, bal_en_o, upd_o, len_err_o, rej_o;
    logic [3:0]  rec_en_o;
    logic [41:0] vol_code_o;
    logic [5:0]  vol_mute_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl3w_rx dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .ser_lat_i(ser_lat), .src_sel_o(src_sel_o), .in_att_o(in_att_o),
        .in_gain_o(in_gain_o), .out_gain_o(out_gain_o), .mute_all_o(mute_all_o),
        .rec_en_o(rec_en_o), .vol_code_o(vol_code_o), .vol_mute_o(vol_mute_o),
        .tone_att_o(tone_att_o), .tone_en_o(tone_en_o), .loud_en_o(loud_en_o),
        .bal_en_o(bal_en_o), .upd_o(upd_o), .upd_slot_o(upd_slot_o),
        .len_err_o(len_err_o), .rej_o(rej_o));

    int tot_upd = 0, tot_rej = 0, tot_err = 0;
    logic [1:0] last_slot = 2'd0;
    always @(negedge clk) begin
        if (upd_o) begin tot_upd++; last_slot = upd_slot_o; end
        if (rej_o) tot_rej++;
        if (len_err_o) tot_err++;
    end

    int nchk = 0, nfail = 0;
    logic [21:0] ms [4];

    typedef struct packed { logic [1:0] slot; logic [21:0] pay; logic rej; } vec_t;
    localparam vec_t VEC [NV] = '{
        '{2'd0, {4'd3, 2'd1, 2'd2, 2'd3, 1'b0, 4'b1010, 7'd0}, 1'b0},
        '{2'd1, {7'd0, 7'd99, 7'd120, 1'b0}, 1'b0},
        '{2'd2, {7'd45, 7'd1, 7'd98, 1'b0}, 1'b0},
        '{2'd3, {2'd2, 1'b1, 1'b1, 18'd0}, 1'b0},
        '{2'd0, {4'd10, 2'd3, 2'd0, 2'd1, 1'b1, 4'b0101, 7'd0}, 1'b0},
        '{2'd0, {4'd11, 2'd0, 2'd0, 2'd0, 1'b0, 4'b0000, 7'd0}, 1'b1},
        '{2'd0, {4'd15, 2'd1, 2'd1, 2'd1, 1'b0, 4'b1111, 7'd0}, 1'b1},
        '{2'd1, {7'd100, 7'd5, 7'd5, 1'b0}, 1'b1},
        '{2'd2, {7'd3, 7'd4, 7'd127, 1'b0}, 1'b1},
        '{2'd2, {7'd121, 7'd4, 7'd4, 1'b0}, 1'b1},
        '{2'd1, {7'd120, 7'd120, 7'd120, 1'b0}, 1'b0},
        '{2'd3, {2'd3, 1'b0, 1'b0, 18'd0}, 1'b0},
        '{2'd0, {4'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'b0000, 7'd1}, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        ms[0] = {4'd0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd0, 7'd0};
        ms[1] = {7'd120, 7'd120, 7'd120, 1'b0};
        ms[2] = {7'd120, 7'd120, 7'd120, 1'b0};
        ms[3] = 22'd0;
    endtask

    task automatic check_outputs();
        chk("R5", "selector", 64'(src_sel_o), 64'(ms[0][21:18]));
        chk("R6", "in_att",   64'(in_att_o),   64'(ms[0][17:16]));
        chk("R6", "in_gain",  64'(in_gain_o),  64'(ms[0][15:14]));
        chk("R6", "out_gain", 64'(out_gain_o), 64'(ms[0][13:12]));
        chk("R3", "mute_all", 64'(mute_all_o), 64'(ms[0][11]));
        chk("R3", "rec_en",   64'(rec_en_o),   64'(ms[0][10:7]));
        for (int j = 0; j < 6; j++) begin
            logic [6:0] v;
            v = ms[(j < 3) ? 1 : 2][21 - 7*(j%3) -: 7];
            chk("R4", "vol_code", 64'(vol_code_o[7*j +: 7]), 64'(v));
            chk("R4", "vol_mute", 64'(vol_mute_o[j]), 64'(v == 7'd120));
        end
        chk("R6",  "tone_att", 64'(tone_att_o), 64'(ms[3][21:20]));
        chk("R3",  "tone_en",  64'(tone_en_o),  64'(ms[3][18]));
        chk("R11", "loud_en",  64'(loud_en_o),  64'(ms[3][19]));
        chk("R11", "bal_en",   64'(bal_en_o),   64'(!ms[3][19]));
    endtask

    task automatic send_bits(input logic [23:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            ser_dat = w[23 - (i % 24)];
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic pulse_latch();
        repeat (HALF) @(negedge clk);
        ser_lat = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_lat = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    // kind: 0 accepted, 1 rejected, 2 length error
    task automatic judge(input string req, input logic [1:0] slot,
                         input logic [21:0] pay, input int kind,
                         input int bu, input int br, input int be);
        chk(req, "upd count", 64'(tot_upd - bu), 64'(kind == 0));
        chk(req, "rej count", 64'(tot_rej - br), 64'(kind == 1));
        chk(req, "err count", 64'(tot_err - be), 64'(kind == 2));
        if (kind == 0) begin
            chk("R10", "upd slot", 64'(last_slot), 64'(slot));
            ms[slot] = pay;
        end
        check_outputs();
    endtask

    task automatic do_frame(input string req, input logic [1:0] slot,
                            input logic [21:0] pay, input int kind);
        int bu, br, be;
        bu = tot_upd; br = tot_rej; be = tot_err;
        send_bits({pay, slot}, 24);
        pulse_latch();
        judge(req, slot, pay, kind, bu, br, be);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL all watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int bu, br, be;
        logic [21:0] p;
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R7 reset defaults, no strobes
        check_outputs();
        chk("R7", "no strobes", 64'(tot_upd + tot_rej + tot_err), 64'd0);

        // R1 R9 table walk
        for (int v = 0; v < NV; v++)
            do_frame(VEC[v].rej ? "R9" : "R1", VEC[v].slot, VEC[v].pay,
                     VEC[v].rej ? 1 : 0);

        // R2 shifting without latch changes nothing
        p = {4'd7, 2'd2, 2'd1, 2'd0, 1'b0, 4'b0011, 7'd0};
        bu = tot_upd; br = tot_rej; be = tot_err;
        send_bits({p, 2'd0}, 24);
        repeat (10) @(negedge clk);
        chk("R2", "no update before latch", 64'(tot_upd - bu), 64'd0);
        check_outputs();
        pulse_latch();
        judge("R2", 2'd0, p, 0, bu, br, be);

        // R8 short and long frames
        bu = tot_upd; br = tot_rej; be = tot_err;
        send_bits({22'd5, 2'd3}, 23);
        pulse_latch();
        judge("R8", 2'd3, 22'd0, 2, bu, br, be);
        bu = tot_upd; br = tot_rej; be = tot_err;
        send_bits({7'd9, 7'd9, 7'd9, 1'b0, 2'd1}, 25);
        pulse_latch();
        judge("R8", 2'd1, 22'd0, 2, bu, br, be);

        // R12 latch rise together with final clock rise; last bit D23 = 1 -> slot 1
        p = {7'd12, 7'd34, 7'd56, 1'b0};
        bu = tot_upd; br = tot_rej; be = tot_err;
        send_bits({p, 2'd1}, 23);
        ser_dat = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b1;
        ser_lat = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b0;
        ser_lat = 1'b0;
        repeat (HALF) @(negedge clk);
        judge("R12", 2'd1, p, 0, bu, br, be);

        // R7 reset during a partial frame restores defaults and clears the count
        send_bits({22'h3FFFFF, 2'd3}, 10);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_outputs();
        bu = tot_upd; br = tot_rej; be = tot_err;
        p = {2'd1, 1'b1, 1'b0, 18'd0};
        send_bits({p, 2'd3}, 24);
        pulse_latch();
        judge("R7", 2'd3, p, 0, bu, br, be);

        summary();
        $finish;
    end
endmodule